// File: doc/BRIEF.md
# I2C register-access slave

This block is a byte-oriented I2C slave that lets an external host read and write a small register file through one internal address pointer. A fast system clock oversamples SCL and SDA. From the sampled lines the block finds START, repeated START and STOP conditions. It compares each address byte with a 7-bit device address picked by a strap pin and acknowledges a match.

The first data byte of a write transfer loads the 5-bit pointer. Every later byte in that transfer is written to the location the pointer names, and the pointer then steps by one. To read, the host writes the pointer byte, issues a repeated START with the read bit set, and then receives bytes from successive locations until it answers with NACK. The pointer keeps its value between transfers, so a later read that does not set the pointer carries on where the last one stopped.

Towards the rest of the chip the block offers a plain register port: an address, a one-cycle write strobe with write data, and a read-data input that is sampled combinationally. Locations at or above a mapped limit return 00h and cannot be written. SDA is driven only through an active-high pull-low enable.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is asserted and just after it, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: The device address is 0x29 when `addr_sel` is 0 and 0x56 when `addr_sel` is 1. The address byte carries the address in bits 7..1, and bit 0 is the direction (0 write, 1 read). On a match the slave pulls SDA low during the ninth clock.
- R3: An address byte that does not match gets no acknowledge, and the rest of that transfer up to the next START or STOP is ignored: no data byte is acknowledged and no register is written.
- R4: In a write transfer, the first byte after the address byte loads the pointer, and `reg_addr` then shows that value.
- R5: Each later byte in a write transfer is acknowledged and is written to the location at the pointer with a `reg_we` strobe. The pointer then increments by one.
- R6: After a write of the pointer byte and a repeated START with the read bit set, the slave sends the byte at the pointer MSB first. It continues with the next locations for as long as the master acknowledges.
- R7: After the master NACKs a read byte, the slave releases SDA and ignores the bus until the next START or STOP. The pointer has advanced once per byte sent, so a new read transfer that does not set the pointer starts at the next location.
- R8: The pointer wraps from 31 to 0, for both writes and reads.
- R9: Locations at or above MAPPED_REGS (24 by default) read as 00h, and writes to them have no effect.
- R10: `sda_oe` becomes active only while SCL is low.
- R11: `reg_we` is a single-cycle strobe, and it is raised only for a mapped location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| addr_sel | input | 1 | Strap: 0 selects address 0x29, 1 selects 0x56 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 5 | Register address (the pointer) |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for reg_addr, combinational |

## Verification
The assertions assume that each SCL and SDA level lasts several system clocks longer than the synchronizer depth. They also assume that SDA moves while SCL is high only to form START or STOP, and that the master never issues STOP while the slave is pulling SDA low. The bench holds each quarter of an SCL period for ten system clocks and changes SDA one quarter into the low phase. It issues STOP only after an acknowledge has ended or after a NACK, so the stimulus stays inside these limits. The bench also keeps the strap steady during every transfer.

// File: rtl/i2c_regslave_pkg.sv
// Shared types for the I2C register slave.
// Assumes: 7-bit addressing only.
package i2c_regslave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } slv_state_t;

    localparam logic [6:0] DEV_ADDR_LO = 7'h29;
    localparam logic [6:0] DEV_ADDR_HI = 7'h56;
    localparam int         BYTE_W      = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into clk and decodes SCL edges and bus conditions.
// Assumes: each line level lasts longer than SYNC_STAGES+1 clk cycles and SYNC_STAGES >= 2.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] line_in;
    logic [1:0] line_s;
    logic [1:0] line_q;

    assign line_in = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [SYNC_STAGES-1:0] stg;
        // Shift chain that brings one bus line into clk (idle bus is high).
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= '1;
            else        stg <= {stg[SYNC_STAGES-2:0], line_in[g]};
        end
        assign line_s[g] = stg[SYNC_STAGES-1];
    end

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= line_s;
    end

    assign sda_s     = line_s[0];
    assign scl_rise  = line_s[1] & ~line_q[1];
    assign scl_fall  = ~line_s[1] & line_q[1];
    assign start_det = line_s[1] & line_q[1] & line_q[0] & ~line_s[0];
    assign stop_det  = line_s[1] & line_q[1] & ~line_q[0] & line_s[0];
endmodule

// File: rtl/i2c_ptr.sv
// Register address pointer: loads a value or steps by one, wrapping modulo 2**PTR_W.
// Assumes: load and inc are never both requested (load wins if they are).
module i2c_ptr #(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/i2c_regslave.sv
// I2C slave with a register port and an auto-incrementing pointer.
// Assumes: clk oversamples SCL by far more than SYNC_STAGES+1 cycles per level;
// no clock stretching; PTR_W <= 8; reg_rdata answers reg_addr combinationally.
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter int PTR_W       = 5,
    parameter int MAPPED_REGS = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int              CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [PTR_W:0]   MAP_LIM  = (PTR_W + 1)'(MAPPED_REGS);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    slv_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] tx;
    logic              ptr_pending;
    logic              master_ack;
    logic              ptr_load, ptr_inc, mapped, busy_evt;
    logic [BYTE_W-1:0] rd_byte;
    logic [6:0]        my_addr;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (rx[PTR_W-1:0]),
        .inc      (ptr_inc),
        .ptr      (reg_addr)
    );

    // Strap decode, map check and read-data gating for unmapped locations.
    always_comb begin
        my_addr  = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;
        mapped   = {1'b0, reg_addr} < MAP_LIM;
        rd_byte  = mapped ? reg_rdata : '0;
        busy_evt = start_det | stop_det;
    end

    // Pointer load on the first write byte, step after each data byte.
    always_comb begin
        ptr_load = !busy_evt && state == ST_WR && scl_fall && cnt == CNT_FULL && ptr_pending;
        ptr_inc  = !busy_evt && scl_fall &&
                   ((state == ST_WR_ACK && !ptr_pending) ||
                    (state == ST_RD && cnt == CNT_LAST));
    end

    // Transfer sequencer: bit counting, shifting, acknowledge and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            rx          <= '0;
            tx          <= '0;
            ptr_pending <= 1'b0;
            master_ack  <= 1'b0;
            sda_oe      <= 1'b0;
            reg_we      <= 1'b0;
            reg_wdata   <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            rx  <= {rx[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            if (state == ST_ADDR) begin
                                if (rx[BYTE_W-1:1] == my_addr) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_SKIP;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                                if (!ptr_pending && mapped) begin
                                    reg_we    <= 1'b1;
                                    reg_wdata <= rx;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rx[0]) begin
                                state  <= ST_RD;
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                            end else begin
                                state       <= ST_WR;
                                sda_oe      <= 1'b0;
                                ptr_pending <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe      <= 1'b0;
                            cnt         <= '0;
                            ptr_pending <= 1'b0;
                            state       <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_RD_ACK;
                            end else begin
                                cnt    <= cnt + 1'b1;
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                state  <= ST_RD;
                            end else begin
                                state  <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
// Checker for i2c_regslave, attached by bind.
// Assumes: bus stimulus keeps the limits stated in the brief.
module i2c_regslave_chk #(
    parameter int PTR_W       = 5,
    parameter int MAPPED_REGS = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             reg_we,
    input logic [PTR_W-1:0] reg_addr
);
    localparam logic [PTR_W:0] LIM = (PTR_W + 1)'(MAPPED_REGS);

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R10

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R11

    AST_WE_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ({1'b0, reg_addr} < LIM)); // R9

    AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe); // R5

    AST_WE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $stable(reg_addr)); // R5
endmodule

bind i2c_regslave i2c_regslave_chk #(
    .PTR_W       (PTR_W),
    .MAPPED_REGS (MAPPED_REGS)
) u_chk (.*);

// File: tb/test_i2c_regslave.sv
// Bench for i2c_regslave: a vector table of single writes with read-back, then directed tests.
module test_i2c_regslave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [32];
    int         n_chk = 0;
    int         n_err = 0;
    int         oe_hi_rise = 0;
    int         we_long = 0;
    logic       we_q = 1'b0;
    logic       oe_q = 1'b0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regslave i_i2c_regslave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    initial for (int i = 0; i < 32; i++) mem[i] = 8'h00;

    // Register file model and bus-rule monitors (R10, R11).
    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (rst_n && sda_oe && !oe_q && scl_m) oe_hi_rise <= oe_hi_rise + 1;
        if (rst_n && reg_we && we_q) we_long <= we_long + 1;
        we_q <= reg_we;
        oe_q <= sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw(); qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl_m = 1'b1; qw(); qw();
            scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        acked = !sda_bus; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl_m = 1'b1; qw();
            b[i] = sda_bus; qw();
            scl_m = 1'b0;
        end
        qw();
        sda_m = give_ack ? 1'b0 : 1'b1; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    // Write transfer: pointer byte then n data bytes (d[31:24] first). Returns address and data acks.
    task automatic write_burst(input logic [6:0] dev, input logic [4:0] p, input int n,
                               input logic [31:0] d, output logic a_ack, output logic d_ack);
        logic ak;
        bus_start();
        send_byte({dev, 1'b0}, a_ack);
        send_byte({3'b000, p}, d_ack);
        for (int k = 0; k < n; k++) begin
            send_byte(d[31-8*k -: 8], ak);
            d_ack = d_ack & ak;
        end
        bus_stop();
    endtask

    // Read transfer of n bytes, last one NACKed; optionally sets the pointer first.
    task automatic read_burst(input logic [6:0] dev, input logic setp, input logic [4:0] p,
                              input int n, output logic [31:0] got);
        logic ak;
        logic [7:0] b;
        got = '0;
        bus_start();
        if (setp) begin
            send_byte({dev, 1'b0}, ak);
            send_byte({3'b000, p}, ak);
            bus_start();
        end
        send_byte({dev, 1'b1}, ak);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            got[31-8*k -: 8] = b;
        end
        bus_stop();
    endtask

    // {strap, pointer, write data, expected read-back}
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 8'd0,  8'h5A, 8'h5A},
        {1'b0, 8'd2,  8'h3C, 8'h3C},
        {1'b1, 8'd5,  8'hC3, 8'hC3},
        {1'b1, 8'd17, 8'h01, 8'h01},
        {1'b0, 8'd23, 8'hFF, 8'hFF},
        {1'b1, 8'd24, 8'h77, 8'h00},
        {1'b0, 8'd25, 8'h99, 8'h00},
        {1'b1, 8'd31, 8'hE7, 8'h00}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic aa, da;
        logic [31:0] got;
        logic [6:0] dev;
        logic [4:0] p;

        repeat (4) @(negedge clk);
        check("R1 sda_oe in reset", {31'b0, sda_oe}, 0);
        check("R1 reg_we in reset", {31'b0, reg_we}, 0);
        check("R1 reg_addr in reset", {27'b0, reg_addr}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 outputs after reset", {26'b0, sda_oe, reg_we, reg_addr}, 0);

        // Vector table: single write then read-back via repeated START.
        for (int v = 0; v < 8; v++) begin
            addr_sel = VEC[v][24];
            dev = VEC[v][24] ? 7'h56 : 7'h29;
            p = VEC[v][20:16];
            write_burst(dev, p, 1, {VEC[v][15:8], 24'h0}, aa, da);
            check("R2 address ack", {31'b0, aa}, 1);
            check("R5 data ack", {31'b0, da}, 1);
            check("R5 pointer stepped", {27'b0, reg_addr}, {27'b0, p + 5'd1});
            read_burst(dev, 1'b1, p, 1, got);
            check("R6 R9 read-back", {24'b0, got[31:24]}, {24'b0, VEC[v][7:0]});
        end

        // Wrong address is not acknowledged and writes nothing.
        addr_sel = 1'b0;
        write_burst(7'h56, 5'd2, 1, 32'hEE00_0000, aa, da);
        check("R3 wrong address nack", {31'b0, aa}, 0);
        check("R3 data ignored", {31'b0, da}, 0);
        read_burst(7'h29, 1'b1, 5'd2, 1, got);
        check("R3 register untouched", {24'b0, got[31:24]}, 32'h3C);

        // Pointer-only write loads the pointer.
        write_burst(7'h29, 5'd7, 0, 32'h0, aa, da);
        check("R4 pointer loaded", {27'b0, reg_addr}, 7);

        // Burst write and burst read.
        write_burst(7'h29, 5'd10, 4, 32'h1122_3344, aa, da);
        check("R5 burst acks", {30'b0, aa, da}, 3);
        read_burst(7'h29, 1'b1, 5'd10, 3, got);
        check("R6 burst read", got, 32'h1122_3300);
        check("R7 pointer after nack", {27'b0, reg_addr}, 13);
        check("R7 SDA released after nack", {31'b0, sda_oe}, 0);
        read_burst(7'h29, 1'b0, 5'd0, 1, got);
        check("R7 read continues", {24'b0, got[31:24]}, 32'h44);

        // Wrap-around from 31 to 0.
        write_burst(7'h29, 5'd31, 2, 32'hAABB_0000, aa, da);
        check("R8 pointer wrapped on write", {27'b0, reg_addr}, 1);
        read_burst(7'h29, 1'b1, 5'd31, 2, got);
        check("R8 R9 wrapped read", {16'b0, got[31:16]}, 32'h00BB);
        check("R8 pointer wrapped on read", {27'b0, reg_addr}, 1);

        check("R10 sda_oe rose with SCL high", oe_hi_rise, 0);
        check("R11 reg_we longer than one cycle", we_long, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule